// File: doc/BRIEF.md
# Vectored Interrupt Controller with Index-Based Enables

The block collects a set of interrupt request lines (64 by default) and drives a single interrupt line toward a processor. Each request line is edge-sensitive: a low-to-high transition on a line marks that source as pending, and the mark stays until software acknowledges it. A source only counts toward the output line while software has switched it on.

Software talks to the block over a simple word-addressed register bus. It switches a single source on or off by writing that source's number to one of two command words. It does not write a bitmask. It services interrupts by reading a vector word. That read returns the number of the lowest-numbered source that is both pending and switched on, and in the same access it acknowledges that source by clearing its pending mark. A plain control word holds whatever software last wrote to it. A band of further word addresses accepts writes and discards them, so that driver code written for a richer controller keeps working.

Read data is registered: the value for a read issued in one cycle appears on the read-data port after the next rising clock edge, and it holds until the next read.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every pending and enable bit is clear, the interrupt output is low, the read-data port is zero and the control word reads zero.
- R2: A low-to-high transition on a request input sets that source's pending bit at the next clock edge. A request held high does not set the bit again after it has been acknowledged.
- R3: The interrupt output is high exactly when at least one source is both pending and enabled.
- R4: A write to word address 0 stores all 32 data bits, and a later read of address 0 returns them unchanged.
- R5: A write to word address 2 with data N, where N is below the source count, enables source N and leaves every other source unchanged.
- R6: A write to word address 3 with data N, where N is below the source count, disables source N and leaves every other source unchanged.
- R7: A read of word address 16 returns the lowest-numbered source that is pending and enabled in bits 31:16, with bits 15:0 zero.
- R8: The address-16 read that returns source N clears source N's pending bit at the same clock edge.
- R9: An address-16 read while no source is both pending and enabled returns 0xFFFF in bits 31:16 and zero in bits 15:0, and it changes no state.
- R10: Writes to word addresses 4 through 15 change neither the control word nor any enable or pending bit.
- R11: When a new rising request edge on source N arrives in the same cycle as the address-16 read that acknowledges N, the pending bit of N stays set.
- R12: Enable and disable writes whose data is not below the source count have no effect.
- R13: Reads of word addresses 2 and 3 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | NUM_SRC | Request lines, one per source, edge-sensitive |
| bus_addr | input | ADDR_W | Word address of the access |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_rdata | output | DATA_W | Registered read data, valid after the edge that samples bus_rd |
| irq_o | output | 1 | Interrupt line to the processor |

## Verification
The bench builds the block with its default configuration: 64 sources, a 6-bit word address and a 32-bit data word. At that size every source number can be walked through pulse, enable, vector read, acknowledge and disable, and every word address in the discarded band can be written. A model of the pending and enable bits held in the bench gives the expected vector for interleaved enable patterns across all 64 sources, so the lowest-first order is checked over the whole range. Out-of-range enable data (64 and above, and all-ones) checks that the index is never truncated into an alias of a real source.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
    // Word offsets that the register decoder uses
    localparam int unsigned OFS_CTRL   = 0;
    localparam int unsigned OFS_EN_SET = 2;
    localparam int unsigned OFS_EN_CLR = 3;
    localparam int unsigned OFS_IGN_LO = 4;
    localparam int unsigned OFS_IGN_HI = 15;
    localparam int unsigned OFS_VEC    = 16;
    // Vector field width and the code returned when nothing is eligible
    localparam int unsigned VEC_W      = 16;
    localparam logic [VEC_W-1:0] VEC_NONE = 16'hFFFF;
endpackage

// File: rtl/ivc_src_bank.sv
module ivc_src_bank #(
    parameter int unsigned NUM_SRC = 64,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req,
    input  logic               ack_vld,
    input  logic [IDX_W-1:0]   ack_idx,
    input  logic               en_set,
    input  logic               en_clr,
    input  logic [IDX_W-1:0]   cmd_idx,
    output logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] en
);
    logic [NUM_SRC-1:0] req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic rise;
        logic hit_ack;
        logic hit_cmd;

        assign rise    = req[g] & ~req_q[g];
        assign hit_ack = ack_vld && (ack_idx == IDX_W'(g));
        assign hit_cmd = (cmd_idx == IDX_W'(g));

        // A fresh edge outranks an acknowledge in the same cycle
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       pend[g] <= 1'b0;
            else if (rise)    pend[g] <= 1'b1;
            else if (hit_ack) pend[g] <= 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  en[g] <= 1'b0;
            else if (en_set && hit_cmd)  en[g] <= 1'b1;
            else if (en_clr && hit_cmd)  en[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/ivc_lowest_pick.sv
module ivc_lowest_pick #(
    parameter int unsigned NUM_SRC = 64,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] cand,
    output logic [IDX_W-1:0]   idx,
    output logic               vld
);
    // Scan from the top down so the lowest set bit is the last to assign
    always_comb begin
        idx = '0;
        vld = 1'b0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                idx = IDX_W'(i);
                vld = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import ivc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_rd,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o
);
    localparam int unsigned IDX_W   = $clog2(NUM_SRC);
    localparam int unsigned VEC_LSB = DATA_W - VEC_W;

    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] eligible;
    logic [IDX_W-1:0]   win_idx;
    logic               win_vld;
    logic [DATA_W-1:0]  ctrl_q;
    logic [DATA_W-1:0]  rd_next;
    logic               idx_in_range;
    logic               wr_ctrl;
    logic               wr_set;
    logic               wr_clr;
    logic               vec_rd;

    assign idx_in_range = (bus_wdata < DATA_W'(NUM_SRC));
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_set  = bus_wr && (bus_addr == ADDR_W'(OFS_EN_SET)) && idx_in_range;
    assign wr_clr  = bus_wr && (bus_addr == ADDR_W'(OFS_EN_CLR)) && idx_in_range;
    assign vec_rd  = bus_rd && (bus_addr == ADDR_W'(OFS_VEC));

    ivc_src_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (irq_req),
        .ack_vld (vec_rd && win_vld),
        .ack_idx (win_idx),
        .en_set  (wr_set),
        .en_clr  (wr_clr),
        .cmd_idx (bus_wdata[IDX_W-1:0]),
        .pend    (pend_q),
        .en      (en_q)
    );

    assign eligible = pend_q & en_q;

    ivc_lowest_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .cand (eligible),
        .idx  (win_idx),
        .vld  (win_vld)
    );

    assign irq_o = |eligible;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= bus_wdata;
    end

    always_comb begin
        rd_next = '0;
        if (bus_addr == ADDR_W'(OFS_CTRL)) begin
            rd_next = ctrl_q;
        end else if (bus_addr == ADDR_W'(OFS_VEC)) begin
            rd_next[DATA_W-1:VEC_LSB] = win_vld ? VEC_W'(win_idx) : VEC_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
    import ivc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned DATA_W  = 32,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_req,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               bus_rd,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] en,
    input logic [IDX_W-1:0]   win_idx,
    input logic               win_vld
);
    logic [NUM_SRC-1:0] req_prev;
    logic [NUM_SRC-1:0] edges;
    logic               vec_access;
    logic               ign_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_prev <= '0;
        else        req_prev <= irq_req;
    end

    assign edges      = irq_req & ~req_prev;
    assign vec_access = bus_rd && (bus_addr == ADDR_W'(OFS_VEC));
    assign ign_wr     = bus_wr && (bus_addr >= ADDR_W'(OFS_IGN_LO))
                               && (bus_addr <= ADDR_W'(OFS_IGN_HI));

    AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (edges != '0) |=> ((pend & $past(edges)) == $past(edges))); // R2

    AST_ENABLE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_EN_SET) && bus_wdata < DATA_W'(NUM_SRC))
        |=> en[$past(bus_wdata[IDX_W-1:0])]); // R5

    AST_DISABLE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_EN_CLR) && bus_wdata < DATA_W'(NUM_SRC))
        |=> !en[$past(bus_wdata[IDX_W-1:0])]); // R6

    AST_VEC_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_access && win_vld)
        |=> (bus_rdata[VEC_W-1:0] == '0) && (bus_rdata[DATA_W-1:DATA_W-VEC_W] < VEC_W'(NUM_SRC))); // R7

    AST_VEC_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_access && win_vld && !edges[win_idx]) |=> !pend[$past(win_idx)]); // R8

    AST_VEC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_access && (pend & en) == '0 && edges == '0)
        |=> (bus_rdata[DATA_W-1:DATA_W-VEC_W] == VEC_NONE) && $stable(pend)); // R9

    AST_IGNORED_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        ign_wr |=> $stable(en)); // R10

    AST_EDGE_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_access && win_vld && edges[win_idx]) |=> pend[$past(win_idx)]); // R11

    AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ADDR_W'(OFS_EN_SET) || bus_addr == ADDR_W'(OFS_EN_CLR))
         && bus_wdata >= DATA_W'(NUM_SRC)) |=> $stable(en)); // R12
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .pend      (pend_q),
    .en        (en_q),
    .win_idx   (win_idx),
    .win_vld   (win_vld)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
    localparam int NS = 64;
    localparam int AW = 6;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_req = '0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic          irq_o;

    irq_vector_ctrl #(.NUM_SRC(NS), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #2 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Bench model of the architectural state
    logic [NS-1:0] m_pend = '0;
    logic [NS-1:0] m_en   = '0;
    logic [DW-1:0] m_ctrl = '0;

    function automatic logic [DW-1:0] exp_vec();
        for (int i = 0; i < NS; i++)
            if (m_pend[i] && m_en[i]) return DW'(i) << 16;
        return 32'hFFFF_0000;
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 0) m_ctrl = d;
        if (a == 2 && d < NS) m_en[d[5:0]] = 1'b1;
        if (a == 3 && d < NS) m_en[d[5:0]] = 1'b0;
    endtask

    task automatic bus_read(input int a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_rd = 1'b1;
        @(posedge clk);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Vector read checked against the model, then model acknowledge
    task automatic vec_check(input string tag);
        logic [DW-1:0] e;
        logic [DW-1:0] v;
        e = exp_vec();
        bus_read(16, v);
        chk(tag, v, e);
        if (e[31:16] != 16'hFFFF) m_pend[e[21:16]] = 1'b0;
    endtask

    task automatic pulse(input logic [NS-1:0] mask);
        @(negedge clk);
        irq_req = irq_req | mask;
        @(negedge clk);
        irq_req = irq_req & ~mask;
        m_pend = m_pend | mask;
    endtask

    task automatic irq_check(input string tag);
        #1 chk(tag, DW'(irq_o), DW'(|(m_pend & m_en)));
    endtask

    task automatic drain();
        for (int i = 0; i < NS; i++) bus_write(2, DW'(i));
        while (|m_pend) vec_check("R7 drain");
        for (int i = 0; i < NS; i++) bus_write(3, DW'(i));
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1 chk("R1 irq after reset", DW'(irq_o), 0);
        chk("R1 rdata after reset", bus_rdata, 0);
        bus_read(0, v); chk("R1 ctrl after reset", v, 0);
        bus_read(16, v); chk("R1/R9 vector after reset", v, 32'hFFFF_0000);

        // R4: control word holds all bits
        foreach (v[i]) begin end
        bus_write(0, 32'hA5C3_0F96); bus_read(0, v); chk("R4 ctrl pattern A", v, 32'hA5C3_0F96);
        bus_write(0, 32'hFFFF_FFFF); bus_read(0, v); chk("R4 ctrl all ones", v, 32'hFFFF_FFFF);
        bus_write(0, 32'h0000_0001); bus_read(0, v); chk("R4 ctrl bit0", v, 32'h0000_0001);

        // R13: command words read zero
        bus_read(2, v); chk("R13 read of enable word", v, 0);
        bus_read(3, v); chk("R13 read of disable word", v, 0);

        // Per-source sweep: R2 R3 R5 R6 R7 R8 R9
        for (int s = 0; s < NS; s++) begin
            pulse(NS'(1) << s);
            irq_check("R3 pending but disabled");
            bus_write(2, DW'(s));
            irq_check("R5 enable raises irq");
            chk("R5 irq high", DW'(irq_o), 1);
            vec_check("R7 single source vector");
            irq_check("R8 ack lowers irq");
            bus_read(16, v); chk("R9 empty after ack", v, 32'hFFFF_0000);
            bus_write(3, DW'(s));
            pulse(NS'(1) << s);
            irq_check("R6 disabled source silent");
            chk("R6 irq low", DW'(irq_o), 0);
            bus_write(2, DW'(s));
            vec_check("R8 re-enabled vector");
            bus_write(3, DW'(s));
        end

        // R2: held level does not re-pend after acknowledge
        @(negedge clk); irq_req[9] = 1'b1; m_pend[9] = 1'b1;
        bus_write(2, 9);
        vec_check("R2 held source vector");
        repeat (4) @(negedge clk);
        irq_check("R2 held level no re-pend");
        bus_read(16, v); chk("R2 held level vector empty", v, 32'hFFFF_0000);
        @(negedge clk); irq_req[9] = 1'b0;
        bus_write(3, 9);

        // R7: lowest-first order over interleaved enable patterns
        for (int p = 2; p <= 7; p++) begin
            pulse('1);
            for (int s = 0; s < NS; s++)
                if ((s % p) == (p - 2)) bus_write(2, DW'(s));
            irq_check("R3 pattern irq");
            while (|(m_pend & m_en)) vec_check("R7 ordered vector");
            irq_check("R3 pattern drained");
            bus_read(16, v); chk("R9 pattern drained", v, 32'hFFFF_0000);
            drain();
        end

        // R10: ignored band
        pulse(NS'(1) << 5);
        bus_write(2, 5);
        bus_write(0, 32'h1234_5678);
        for (int a = 4; a <= 15; a++) begin
            @(negedge clk);
            bus_addr = AW'(a); bus_wdata = 32'd5; bus_wr = 1'b1;
            @(negedge clk);
            bus_wr = 1'b0;
            irq_check("R10 ignored write irq");
        end
        bus_read(0, v); chk("R10 ctrl unchanged", v, 32'h1234_5678);
        pulse(NS'(1) << 6);
        for (int a = 4; a <= 15; a++) begin
            @(negedge clk);
            bus_addr = AW'(a); bus_wdata = 32'd6; bus_wr = 1'b1;
            @(negedge clk);
            bus_wr = 1'b0;
        end
        irq_check("R10 source 6 still disabled");
        vec_check("R10 vector source 5");
        bus_read(16, v); chk("R10 source 6 not enabled", v, 32'hFFFF_0000);
        drain();

        // R12: out-of-range command data
        pulse(NS'(1) << 3);
        bus_write(2, 64 + 3);
        bus_write(2, 32'hFFFF_FFFF);
        bus_write(2, 32'h0001_0003);
        irq_check("R12 out of range enable");
        chk("R12 irq low", DW'(irq_o), 0);
        bus_write(2, 3);
        bus_write(3, 64 + 3);
        bus_write(3, 32'hFFFF_FFC3);
        irq_check("R12 out of range disable");
        chk("R12 irq high", DW'(irq_o), 1);
        vec_check("R12 vector source 3");
        bus_write(3, 3);

        // R11: new edge in the acknowledge cycle keeps the bit
        pulse(NS'(1) << 7);
        bus_write(2, 7);
        @(negedge clk);
        bus_addr = AW'(16); bus_rd = 1'b1; irq_req[7] = 1'b1;
        @(posedge clk);
        #1 chk("R11 vector returns 7", bus_rdata, 32'h0007_0000);
        chk("R11 irq stays high", DW'(irq_o), 1);
        @(negedge clk);
        bus_rd = 1'b0; irq_req[7] = 1'b0;
        vec_check("R11 second vector");
        irq_check("R11 finally low");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule